// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Timed Refresh

This block sits between a simple synchronous requester and an asynchronous DRAM device whose address pins are shared between row and column. A request carries a write flag, a full word address and write data; the controller captures them, places the upper (row) half of the address on the shared pins and lowers the row strobe, then places the lower (column) half and lowers the column strobe. The write-enable level at that moment picks read or write. Every interval, which is derived from the system clock frequency and the retention budget per row, it runs a column-before-row refresh cycle that uses the device's internal row counter.

All strobe widths are parameters given in clock cycles: the row-to-column delay, the minimum row-strobe low time and the row precharge time. A pending refresh takes priority over a new request, but never cuts short an access that has already started. Reads return the word in the same cycle as a one-clock completion pulse.

Top module: `adram_ctrl`

## Requirements
- R1: After reset all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is low and `done` is low.
- R2: When `dram_ras_n` falls for an access, `dram_addr` holds `req_addr[ROW_W+COL_W-1:COL_W]`; when `dram_cas_n` falls, it holds `req_addr[COL_W-1:0]`. The pins do not change on the edge where either strobe falls.
- R3: When `dram_cas_n` falls, `dram_we_n` is 1 for a read and 0 for a write. For a write, `dram_dq_oe` is 1 and `dram_dq_o` holds the write data at that point.
- R4: `dram_oe_n` is low only during reads, and only while `dram_dq_oe` is 0.
- R5: Each accepted request produces `done` high for exactly one clock. For a read, `rd_data` holds the addressed word in that same cycle.
- R6: The row strobe stays low for at least `T_RAS` cycles. The column strobe falls at least `T_RCD` cycles after the row strobe. The row strobe stays high for at least `T_RP` cycles between cycles.
- R7: A refresh cycle lowers `dram_cas_n` while `dram_ras_n` is high and `dram_we_n` is high, then lowers `dram_ras_n`. One refresh is issued per `CLK_KHZ*REF_NS/1000000` clock cycles.
- R8: If a refresh is due in the same cycle that a request is waiting in idle, the refresh cycle runs first and the access follows it.
- R9: Once an access has lowered its row strobe, the row strobe is not raised before its column strobe has fallen, and no refresh starts until the access has released both strobes.
- R10: Address, write data and write flag are captured when a request is accepted. Changing them afterwards while `req` stays high has no effect on the access.
- R11: The requester holds `req` until it sees `done` and drops it in the following cycle. Exactly one access is performed per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address; upper bits are the row |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid while `done` is high after a read |
| done | output | 1 | One-clock completion pulse |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | DATA_W | Data from the device |

## Verification
The bench runs a behavioural DRAM model that latches row and column on the strobe edges, and it lines a request up with the first refresh so that both arrive in idle on the same edge. If the arbitration were inverted, an access edge would be logged before the refresh. The bench changes the address and data pins once the row strobe is low. A controller that did not latch them would write or read the complemented location, and the shadow memory comparison would catch it. Strobe widths are measured at the pins, so a counter loaded one short would break the row-to-column, low-time or precharge minimums. A refresh tally checked against the elapsed cycles exposes an interval counter that is off by a factor or never reloads.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSET,
    ST_RCD,
    ST_CSET,
    ST_CAS,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_PRE
  } seq_state_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adram_ref_timer.sv
module adram_ref_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CNT_W'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt_q   <= tick ? CNT_W'(INTERVAL - 1) : cnt_q - 1'b1;
      pending <= (pending & ~ack) | tick;
    end
  end

  // R7: a due refresh is not forgotten before it is served
  p_pending_held_r7: assert property (@(posedge clk) disable iff (rst)
    (pending && !ack) |=> pending);

  // R7: the counter always reloads within its range
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(INTERVAL - 1));

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RAS  = 6,
  parameter int unsigned T_RP   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req,
  input  logic                                 req_we,
  input  logic [ROW_W+COL_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  input  logic                                 ref_pending,
  output logic                                 ref_ack,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 done,
  output logic [umax(ROW_W, COL_W)-1:0]        dram_addr,
  output logic                                 dram_ras_n,
  output logic                                 dram_cas_n,
  output logic                                 dram_we_n,
  output logic                                 dram_oe_n,
  output logic [DATA_W-1:0]                    dram_dq_o,
  output logic                                 dram_dq_oe,
  input  logic [DATA_W-1:0]                    dram_dq_i
);
  localparam int unsigned ADDR_W  = ROW_W + COL_W;
  localparam int unsigned MUX_W   = umax(ROW_W, COL_W);
  localparam int unsigned CAS_LEN = (T_RAS > T_RCD + 1 + T_CAS) ? (T_RAS - T_RCD - 1) : T_CAS;
  localparam int unsigned MAXT    = umax(umax(T_RCD, CAS_LEN), umax(T_RAS, T_RP));
  localparam int unsigned CNT_W   = $clog2(MAXT + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wdata;
  logic              last;

  assign last    = (cnt == '0);
  assign ref_ack = (state == ST_IDLE) && ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      lat_addr   <= '0;
      lat_we     <= 1'b0;
      lat_wdata  <= '0;
      rd_data    <= '0;
      done       <= 1'b0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            dram_cas_n <= 1'b0;
            state      <= ST_RF_CAS;
          end else if (req) begin
            lat_addr  <= req_addr;
            lat_we    <= req_we;
            lat_wdata <= req_wdata;
            dram_addr <= MUX_W'(req_addr[ADDR_W-1:COL_W]);
            state     <= ST_RSET;
          end
        end
        ST_RSET: begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RCD - 1);
          state      <= ST_RCD;
        end
        ST_RCD: begin
          if (last) begin
            dram_addr  <= MUX_W'(lat_addr[COL_W-1:0]);
            dram_we_n  <= ~lat_we;
            dram_dq_oe <= lat_we;
            dram_dq_o  <= lat_wdata;
            state      <= ST_CSET;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CSET: begin
          dram_cas_n <= 1'b0;
          dram_oe_n  <= lat_we;
          cnt        <= CNT_W'(CAS_LEN - 1);
          state      <= ST_CAS;
        end
        ST_CAS: begin
          if (last) begin
            if (!lat_we) rd_data <= dram_dq_i;
            done       <= 1'b1;
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            cnt        <= CNT_W'(T_RP - 1);
            state      <= ST_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RF_CAS: begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RAS - 1);
          state      <= ST_RF_RAS;
        end
        ST_RF_RAS: begin
          if (last) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            state      <= ST_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (last) state <= ST_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: shared pins are settled when either strobe falls
  p_row_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  p_col_stable_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

  // R3: write-enable level is settled at the column strobe edge
  p_we_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $stable(dram_we_n));

  // R4: output enable only in reads with the data driver off
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe));

  // R5: completion is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: row strobe is never released while the column strobe stays low
  p_ras_before_cas_r9: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && !dram_cas_n) |=> !(dram_ras_n && !dram_cas_n));

  // R7: a refresh column strobe keeps write enable high
  p_ref_we_high_r7: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && dram_ras_n) |-> dram_we_n);

endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
  import adram_pkg::*;
#(
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned COL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned REF_NS  = 15600,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_CAS   = 2,
  parameter int unsigned T_RAS   = 6,
  parameter int unsigned T_RP    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req,
  input  logic                          req_we,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          done,
  output logic [umax(ROW_W, COL_W)-1:0] dram_addr,
  output logic                          dram_ras_n,
  output logic                          dram_cas_n,
  output logic                          dram_we_n,
  output logic                          dram_oe_n,
  output logic [DATA_W-1:0]             dram_dq_o,
  output logic                          dram_dq_oe,
  input  logic [DATA_W-1:0]             dram_dq_i
);
  localparam longint unsigned REF_RAW = (longint'(CLK_KHZ) * longint'(REF_NS)) / 64'd1000000;
  localparam int unsigned     REF_INTERVAL = (REF_RAW < 64'd2) ? 2 : int'(REF_RAW);

  logic ref_pending;
  logic ref_ack;

  adram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  adram_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
    .T_RCD (T_RCD), .T_CAS (T_CAS), .T_RAS (T_RAS), .T_RP (T_RP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ref_pending (ref_pending),
    .ref_ack     (ref_ack),
    .rd_data     (rd_data),
    .done        (done),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_o   (dram_dq_o),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_i   (dram_dq_i)
  );

endmodule

// File: tb/tb_adram_ctrl.sv
`timescale 1ns/1ps
module tb_adram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 5, COL_W = 5, DW = 8, AW = ROW_W + COL_W;
  localparam int CLK_KHZ = 5000, REF_NS = 15600;
  localparam int T_RCD = 2, T_CAS = 2, T_RAS = 6, T_RP = 2;
  localparam int REF_IV = (CLK_KHZ * REF_NS) / 1000000;
  localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 0, rst = 1;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, dram_dq_o, dram_dq_i;
  logic done, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [MW-1:0] dram_addr;

  adram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .CLK_KHZ(CLK_KHZ),
    .REF_NS(REF_NS), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // behavioural device model and pin-level timing monitor
  logic [DW-1:0] mem    [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  bit m_we = 0, m_dqoe = 0, m_oe = 0, in_acc = 0, saw_cas = 0, mark = 0;
  logic [DW-1:0] m_wd = '0;
  int ref_cnt = 0, first_kind = 0, ras_lo = 0, ras_hi = 1000;
  logic p_ras = 1, p_cas = 1;

  assign dram_dq_i = (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                     ? mem[{m_row, m_col}] : '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ras && !dram_ras_n) begin
        check(ras_hi >= T_RP, "R6 precharge", ras_hi, T_RP);
        if (!dram_cas_n) begin
          ref_cnt++;
          check(dram_we_n == 1'b1, "R7 refresh we_n", dram_we_n, 1);
          check(!in_acc, "R9 refresh inside access", in_acc, 0);
          if (mark) begin first_kind = 2; mark = 0; end
        end else begin
          m_row = dram_addr[ROW_W-1:0];
          in_acc = 1; saw_cas = 0;
          if (mark) begin first_kind = 1; mark = 0; end
        end
        ras_lo = 0;
      end
      if (!p_ras && dram_ras_n) begin
        check(ras_lo >= T_RAS, "R6 ras low", ras_lo, T_RAS);
        if (in_acc) check(saw_cas, "R9 ras released early", saw_cas, 1);
        in_acc = 0; ras_hi = 0;
      end
      if (p_cas && !dram_cas_n && !dram_ras_n && in_acc) begin
        check(ras_lo >= T_RCD, "R6 ras-to-cas", ras_lo, T_RCD);
        m_col = dram_addr[COL_W-1:0];
        saw_cas = 1;
        m_we = !dram_we_n; m_dqoe = dram_dq_oe; m_oe = !dram_oe_n; m_wd = dram_dq_o;
        if (!dram_we_n) mem[{m_row, m_col}] = dram_dq_o;
      end
      if (!dram_oe_n)
        check(dram_we_n && !dram_dq_oe, "R4 oe outside read", {dram_we_n, dram_dq_oe}, 2);
      if (!dram_ras_n) ras_lo++; else ras_hi++;
      p_ras = dram_ras_n; p_cas = dram_cas_n;
    end
  end

  always @(posedge clk) begin
    if (!rst) cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit scramble);
    int n;
    bit got;
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    n = 0; got = 0;
    while (!got && n < 300) begin
      @(negedge clk);
      n++;
      if (scramble && !dram_ras_n && dram_cas_n) begin
        req_addr = ~a; req_wdata = ~d; req_we = ~we;
      end
      if (done) got = 1;
    end
    check(got, "R5 done never seen", got, 1);
    req = 0;
    check(m_row == a[AW-1:COL_W], "R2 row", m_row, a[AW-1:COL_W]);
    check(m_col == a[COL_W-1:0], "R2 col", m_col, a[COL_W-1:0]);
    check(m_we == we, "R3 op kind", m_we, we);
    if (we) begin
      check(m_dqoe && m_wd == d, "R3 write data", m_wd, d);
      shadow[a] = d;
    end else begin
      check(m_oe, "R4 oe in read", m_oe, 1);
      check(rd_data == shadow[a], scramble ? "R10 read data" : "R5 read data",
            rd_data, shadow[a]);
    end
    @(negedge clk);
    check(done == 1'b0, "R5 done width", done, 0);
  endtask

  initial begin
    int wr_before;
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    check(!dram_dq_oe && !done, "R1 dq_oe/done", {dram_dq_oe, done}, 0);
    // R8: request arrives in idle together with the first due refresh
    repeat (REF_IV) @(posedge clk);
    mark = 1;
    do_op(1'b1, 10'h2A5, 8'h5C, 1'b0);
    check(first_kind == 2, "R8 refresh first", first_kind, 2);
    // R11: one request gives one access
    wr_before = 0;
    do_op(1'b0, 10'h2A5, 8'h00, 1'b0);
    // R10: inputs changed after acceptance
    do_op(1'b1, 10'h013, 8'hA7, 1'b1);
    do_op(1'b0, 10'h013, 8'h00, 1'b1);
    do_op(1'b0, ~10'h013, 8'h00, 1'b0);
    // corners: all-zero and all-one addresses
    do_op(1'b1, '0, 8'hFF, 1'b0);
    do_op(1'b1, '1, 8'h01, 1'b0);
    do_op(1'b0, '0, 8'h00, 1'b0);
    do_op(1'b0, '1, 8'h00, 1'b0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom() % 64);
      do_op(($urandom() % 2) == 1, ra, DW'($urandom()), ($urandom() % 4) == 0);
    end
    // R11: idle with req low produces no access edges
    wr_before = ref_cnt;
    mark = 1;
    repeat (REF_IV / 2) @(negedge clk);
    check(first_kind == 2 || mark, "R11 no stray access", first_kind, 2);
    mark = 0;
    // R7: refresh tally against elapsed cycles
    begin
      int ticks;
      ticks = cyc / REF_IV;
      check(ref_cnt == ticks || ref_cnt == ticks - 1, "R7 refresh count", ref_cnt, ticks);
    end
    finish_run();
  end
endmodule